// File: doc/BRIEF.md
# Oversampling Accumulator with Result Shift

This block takes a stream of 12-bit converter samples, each marked by a valid strobe, and adds up a power-of-two number of them. A 4-bit ratio code selects how many samples make up one window, from 2 to 4096. When the window is complete, the block right-shifts the sum and presents it on a 16-bit result port with a one-cycle valid pulse. The accumulator then starts the next window from zero.

The shift is not the base-2 logarithm of the ratio. For ratios of 2 to 16 the full sum is kept, so the result grows from 13 to 16 significant bits. For larger ratios the sum is shifted right by log2(ratio) minus 4, so the result never needs more than 16 bits. A clear input, or a change of the ratio code, throws away a window that has only partly been collected.

Top module: `ovs_accum`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` is 0 and `res_data` is 0.
- R2: Ratio code c in 0..11 selects a window of N = 2^(c+1) samples (0 = 2x, 3 = 16x, 11 = 4096x). Codes 12 to 15 behave exactly like code 11.
- R3: `res_valid` is high for exactly one cycle, in the cycle that follows the clock edge on which the Nth accepted sample is taken. A cycle with `smp_valid` low adds nothing and does not count.
- R4: For codes 0 to 3, `res_data` is the plain sum of the window. It fits in 13+c bits and is zero-extended to 16 bits.
- R5: For codes 4 to 11, `res_data` is the window sum shifted right by c-3 bits (1 to 8 bits). The bits shifted out are dropped.
- R6: A 4096x window of full-scale samples (4095 each) does not overflow and yields 65520.
- R7: A cycle with `clear` high discards the partial sum and the count. A sample presented in that same cycle is discarded too, and no result is produced for the discarded samples.
- R8: A change of the effective ratio code in the middle of a window discards the partial sum, including any sample presented in the cycle of the change. The next window starts at the new ratio.
- R9: Windows run back to back. The window after a result holds only samples that arrived after that result's last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 4 | Oversampling ratio code |
| clear | input | 1 | Discard the current partial window |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_data | input | 12 | Unsigned sample value |
| res_valid | output | 1 | One-cycle pulse when a result is ready |
| res_data | output | 16 | Shifted sum, zero-extended |

## Verification
Two cases are hard to reach. The first is a discard that lands in the same cycle as a sample, after part of a window has already been collected. The bench first feeds a partial window. It then raises `clear`, or changes the ratio code, in the very cycle that carries a valid sample. Finally it runs a complete window and expects only that window's sum. The second hard case is overflow at the top ratio. The bench reaches it with a full 4096-sample window of the maximum code, presented once through code 11 and once through the out-of-range code 13.

// File: rtl/ovs_accum.sv
module ovs_accum #(
  parameter int SMP_W      = 12,
  parameter int RES_W      = 16,
  parameter int ACC_W      = 24,
  parameter int CODE_W     = 4,
  parameter int MAX_CODE   = 11,
  parameter int FULL_CODES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_sel,
  input  logic              clear,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data
);
  localparam int CNT_W = MAX_CODE + 2;
  localparam int SHIFT_BASE = FULL_CODES - 1;
  localparam logic [ACC_W-1:0] SMP_MAX = ACC_W'((1 << SMP_W) - 1);

  logic [CODE_W-1:0] code_eff, ratio_q, shift;
  logic [CNT_W-1:0]  cnt, last;
  logic [ACC_W-1:0]  acc, sum_next;
  logic              discard;

  assign code_eff = (ratio_sel > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : ratio_sel;
  assign last     = (CNT_W'(2) << ratio_q) - CNT_W'(1);
  assign sum_next = acc + ACC_W'(smp_data);
  assign shift    = (ratio_q < CODE_W'(FULL_CODES)) ? '0 : ratio_q - CODE_W'(SHIFT_BASE);
  assign discard  = clear || (code_eff != ratio_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q   <= '0;
      cnt       <= '0;
      acc       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      ratio_q   <= code_eff;
      if (discard) begin
        acc <= '0;
        cnt <= '0;
      end else if (smp_valid) begin
        if (cnt == last) begin
          res_data  <= RES_W'(sum_next >> shift);
          res_valid <= 1'b1;
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= sum_next;
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_result_needs_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(smp_valid));

  assert_full_sum_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ratio_q < CODE_W'(FULL_CODES)) |-> ((res_data >> (13 + ratio_q)) == '0));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= ACC_W'(cnt) * SMP_MAX);

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0 && acc == '0 && !res_valid));

  assert_ratio_change_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_eff != ratio_q) |=> (cnt == '0 && !res_valid));
endmodule

// File: tb/ovs_accum_tb.sv
module ovs_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ratio_sel = 4'd0;
  logic        clear = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = 12'd0;
  logic        res_valid;
  logic [15:0] res_data;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ovs_accum dut_i (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .clear(clear),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic int sample_val(input int seed, input int i);
    if (seed < 0) return 4095;
    return (seed + i * 173) % 4096;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_code(input int c);
    @(posedge clk); #1;
    smp_valid = 1'b0;
    ratio_sel = 4'(c);
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic drive(input int n, input int seed, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      smp_valid = 1'b1;
      smp_data  = 12'(sample_val(seed, i));
      if (gap && (i % 3 == 2)) begin
        @(posedge clk); #1;
        smp_valid = 1'b0;
      end
    end
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic window(input int code, input int seed, input bit gap, input string tag);
    int eff, n, sum, sh;
    eff = (code > 11) ? 11 : code;
    n = 2 << eff;
    sum = 0;
    for (int i = 0; i < n; i++) sum += sample_val(seed, i);
    sh = (eff < 4) ? 0 : eff - 3;
    exp_q.push_back(sum >> sh);
    tag_q.push_back(tag);
    drive(n, seed, gap);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R7/R8 unexpected result", int'(res_data), -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(res_data) == e, t, int'(res_data), e);
      end
    end
  end

  initial begin
    #200000000;
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0 && res_data == 16'd0, "R1 during reset", int'(res_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0 && res_data == 16'd0, "R1 after reset", int'(res_data), 0);

    for (int c = 0; c <= 11; c++) begin
      set_code(c);
      window(c, 17 * c + 5, c[0], (c < 4) ? "R2 R4 full sum" : "R2 R5 shifted sum");
    end

    set_code(0);
    window(0, 100, 1'b0, "R9 back to back 1");
    window(0, 900, 1'b0, "R9 back to back 2");
    window(0, 2000, 1'b0, "R9 back to back 3");
    set_code(1);
    window(1, 7, 1'b1, "R3 gaps ignored");

    set_code(3);
    drive(7, 300, 1'b0);
    @(posedge clk); #1;
    clear = 1'b1; smp_valid = 1'b1; smp_data = 12'd4000;
    @(posedge clk); #1;
    clear = 1'b0; smp_valid = 1'b0;
    window(3, 55, 1'b0, "R7 clear discards partial");

    set_code(2);
    drive(5, 600, 1'b0);
    @(posedge clk); #1;
    ratio_sel = 4'd1; smp_valid = 1'b1; smp_data = 12'd999;
    window(1, 77, 1'b0, "R8 ratio change discards partial");

    set_code(11);
    window(11, -1, 1'b0, "R6 full scale 4096x");
    set_code(13);
    window(13, -1, 1'b0, "R2 code 13 as 11 full scale");

    repeat (10) @(posedge clk);
    check(exp_q.size() == 0, "R3 missing results", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule